// File: doc/BRIEF.md
# Full-Bridge Direction Dead-Time Controller

This block routes one PWM compare signal onto the four gate-drive lines of a full bridge running a brushed DC motor. A 3-bit mode input picks forward or reverse. In forward, the A line carries the PWM waveform and the D line is held on. In reverse, the C line carries the PWM waveform and the B line is held on. Any other mode value keeps all four lines off.

Software reverses the motor by flipping the direction bit of the mode. The block does not act on the flip at once. It holds the request until the next cycle in which the period-sync pulse is high. In that cycle the old pair is released. If the dead-time value captured when the bit flipped is zero, the new pair drives in that same cycle. Otherwise all four lines stay off for that many clock cycles, counting the sync cycle, before the new pair drives. Dead time is inserted only on a reversal. Ordinary PWM edges pass through with no delay.

Top module: `hbridge_reverse_dt`

## Requirements
- R1: While rst_n is low all four outputs are low. On the first cycle after release in which the mode is 3'b101 or 3'b100, that mode's pair drives at once, with no dead time.
- R2: Mode 3'b101 is forward. Once settled, out_a follows pwm_i, out_d is 1, and out_b and out_c are 0.
- R3: Mode 3'b100 is reverse. Once settled, out_c follows pwm_i, out_b is 1, and out_a and out_d are 0.
- R4: For any mode other than 3'b101 and 3'b100, all outputs are 0 and any pending reversal or dead-time count is dropped. A later return to a brush mode drives that mode's pair at once.
- R5: After mode bit 0 changes between the two brush modes, the outputs keep the old pair until the first cycle with sync_i = 1. The swap happens only in such a cycle.
- R6: If the dead-time value captured for a reversal is 0, the new pair drives in the sync cycle itself.
- R7: If the captured dead-time value N is non-zero, all four outputs are 0 for exactly N cycles, starting with the sync cycle, and the new pair drives in the next cycle.
- R8: The dead-time value is sampled from dead_i in the cycle the direction bit changes. Later changes to dead_i before the sync have no effect on that reversal.
- R9: If the direction bit returns to the applied direction before a sync pulse, the request is cancelled. The next sync neither blanks the outputs nor swaps the pair.
- R10: A sync pulse with no pending reversal leaves the outputs unchanged.
- R11: out_a and out_b are never 1 together, and out_c and out_d are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 3 | Mode: 3'b101 forward, 3'b100 reverse, others off |
| dead_i | input | 6 | Dead-time length in clock cycles, used on reversal |
| pwm_i | input | 1 | PWM compare signal to steer |
| sync_i | input | 1 | PWM period-reset pulse |
| out_a | output | 1 | Bridge line A (PWM in forward) |
| out_b | output | 1 | Bridge line B (held on in reverse) |
| out_c | output | 1 | Bridge line C (PWM in reverse) |
| out_d | output | 1 | Bridge line D (held on in forward) |

## Verification
The assertions check on every cycle the properties that can be judged from a short window. These are: idle modes keep the bridge quiet, neither leg conducts top and bottom at once, each held-on line comes with the correct PWM line, a pair swap lands only in a sync cycle, and a driven pair survives any cycle without sync. The exact length of the blanking window, the capture of the dead-time value at the toggle, and the cancellation of a request that was toggled back can only be shown by the bench's directed scenarios and its cycle-by-cycle comparison against an independent model.

// File: rtl/hbridge_rdt_pkg.sv
package hbridge_rdt_pkg;

  typedef struct packed {
    logic a;
    logic b;
    logic c;
    logic d;
  } bridge_drive_t;

  localparam bridge_drive_t BRIDGE_OFF = '{a: 1'b0, b: 1'b0, c: 1'b0, d: 1'b0};

  // Map an applied direction and the PWM level onto the four lines.
  function automatic bridge_drive_t steer_pair(input logic fwd, input logic pwm);
    bridge_drive_t r;
    r = BRIDGE_OFF;
    if (fwd) begin
      r.a = pwm;
      r.d = 1'b1;
    end else begin
      r.c = pwm;
      r.b = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/hbridge_dir_track.sv
// Tracks the applied direction, the pending reversal request and the
// dead-time value captured when the direction bit toggled.
module hbridge_dir_track #(
  parameter int unsigned         MODE_W   = 3,
  parameter int unsigned         DT_W     = 6,
  parameter logic [MODE_W-1:0]   FWD_MODE = 3'b101,
  parameter logic [MODE_W-1:0]   REV_MODE = 3'b100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DT_W-1:0]   dead_i,
  input  logic              sync_i,
  output logic              brush_o,
  output logic              switch_o,
  output logic              dir_o,
  output logic [DT_W-1:0]   eff_dt_o
);

  logic            want_fwd;
  logic            brush;
  logic            toggle;
  logic            pending;
  logic            switching;
  logic            dir_now;
  logic [DT_W-1:0] eff_dt;

  logic            dir_q,  dir_d;
  logic            req_q,  req_d;
  logic            wv_q,   wv_d;
  logic [DT_W-1:0] hold_q, hold_d;
  logic            hold_en;

  // Decode and request handling
  always_comb begin
    want_fwd  = (mode_i == FWD_MODE);
    brush     = want_fwd || (mode_i == REV_MODE);
    toggle    = brush && wv_q && (want_fwd != req_q);
    eff_dt    = toggle ? dead_i : hold_q;
    pending   = brush && wv_q && (want_fwd != dir_q);
    switching = pending && sync_i;
    dir_now   = (!wv_q || switching) ? want_fwd : dir_q;
  end

  // Next state
  always_comb begin
    wv_d    = brush;
    req_d   = want_fwd;
    dir_d   = brush ? dir_now : want_fwd;
    hold_en = toggle;
    hold_d  = dead_i;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
      req_q <= 1'b0;
      wv_q  <= 1'b0;
    end else begin
      dir_q <= dir_d;
      req_q <= req_d;
      wv_q  <= wv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  assign brush_o  = brush;
  assign switch_o = switching;
  assign dir_o    = dir_now;
  assign eff_dt_o = eff_dt;

endmodule

// File: rtl/hbridge_blank_cnt.sv
// Dead-time down-counter: blanks the bridge for the captured count,
// starting with the sync cycle in which a reversal is applied.
module hbridge_blank_cnt #(
  parameter int unsigned DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            brush_i,
  input  logic            switch_i,
  input  logic [DT_W-1:0] eff_dt_i,
  output logic            blank_o
);

  localparam logic [DT_W-1:0] CNT_ZERO = '0;
  localparam logic [DT_W-1:0] CNT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};

  logic [DT_W-1:0] cnt_q, cnt_d;
  logic            cnt_en;
  logic            dt_nonzero;
  logic            cnt_busy;

  always_comb begin
    dt_nonzero = (eff_dt_i != CNT_ZERO);
    cnt_busy   = (cnt_q != CNT_ZERO);
    cnt_en     = 1'b0;
    cnt_d      = cnt_q;
    if (!brush_i) begin
      cnt_en = cnt_busy;
      cnt_d  = CNT_ZERO;
    end else if (switch_i) begin
      cnt_en = 1'b1;
      cnt_d  = dt_nonzero ? (eff_dt_i - CNT_ONE) : CNT_ZERO;
    end else if (cnt_busy) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_ZERO;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign blank_o = switch_i ? dt_nonzero : cnt_busy;

endmodule

// File: rtl/hbridge_steer.sv
// Output steering: places the PWM and the held-on level on the active diagonal.
module hbridge_steer
  import hbridge_rdt_pkg::*;
(
  input  logic          en_i,
  input  logic          fwd_i,
  input  logic          pwm_i,
  output bridge_drive_t drive_o
);

  always_comb begin
    drive_o = BRIDGE_OFF;
    if (en_i) begin
      drive_o = steer_pair(fwd_i, pwm_i);
    end
  end

endmodule

// File: rtl/hbridge_reverse_dt.sv
module hbridge_reverse_dt
  import hbridge_rdt_pkg::*;
#(
  parameter int unsigned       MODE_W   = 3,
  parameter int unsigned       DT_W     = 6,
  parameter logic [MODE_W-1:0] FWD_MODE = 3'b101,
  parameter logic [MODE_W-1:0] REV_MODE = 3'b100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [DT_W-1:0]   dead_i,
  input  logic              pwm_i,
  input  logic              sync_i,
  output logic              out_a,
  output logic              out_b,
  output logic              out_c,
  output logic              out_d
);

  logic            brush;
  logic            switching;
  logic            dir_now;
  logic [DT_W-1:0] eff_dt;
  logic            blank;
  logic            drive_en;
  bridge_drive_t   drive;

  hbridge_dir_track #(
    .MODE_W   (MODE_W),
    .DT_W     (DT_W),
    .FWD_MODE (FWD_MODE),
    .REV_MODE (REV_MODE)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .dead_i   (dead_i),
    .sync_i   (sync_i),
    .brush_o  (brush),
    .switch_o (switching),
    .dir_o    (dir_now),
    .eff_dt_o (eff_dt)
  );

  hbridge_blank_cnt #(
    .DT_W (DT_W)
  ) u_blank (
    .clk      (clk),
    .rst_n    (rst_n),
    .brush_i  (brush),
    .switch_i (switching),
    .eff_dt_i (eff_dt),
    .blank_o  (blank)
  );

  assign drive_en = rst_n && brush && !blank;

  hbridge_steer u_steer (
    .en_i    (drive_en),
    .fwd_i   (dir_now),
    .pwm_i   (pwm_i),
    .drive_o (drive)
  );

  assign out_a = drive.a;
  assign out_b = drive.b;
  assign out_c = drive.c;
  assign out_d = drive.d;

endmodule

// File: rtl/hbridge_reverse_dt_chk.sv
module hbridge_reverse_dt_chk #(
  parameter int unsigned       MODE_W   = 3,
  parameter logic [MODE_W-1:0] FWD_MODE = 3'b101,
  parameter logic [MODE_W-1:0] REV_MODE = 3'b100
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode_i,
  input logic              pwm_i,
  input logic              sync_i,
  input logic              out_a,
  input logic              out_b,
  input logic              out_c,
  input logic              out_d
);

  logic armed_q;
  logic brush;

  assign brush = (mode_i == FWD_MODE) || (mode_i == REV_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !brush |-> !(out_a || out_b || out_c || out_d));

  assert_no_leg_short_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b) && !(out_c && out_d));

  assert_fwd_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_d |-> (out_a == pwm_i) && !out_b && !out_c);

  assert_rev_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_b |-> (out_c == pwm_i) && !out_a && !out_d);

  assert_swap_on_sync_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ((out_b && $past(out_d)) || (out_d && $past(out_b)))) |-> sync_i);

  assert_hold_fwd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(out_d) && $past(brush) && brush && !sync_i) |-> out_d);

  assert_hold_rev_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && $past(out_b) && $past(brush) && brush && !sync_i) |-> out_b);

endmodule

bind hbridge_reverse_dt hbridge_reverse_dt_chk #(
  .MODE_W   (MODE_W),
  .FWD_MODE (FWD_MODE),
  .REV_MODE (REV_MODE)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode_i (mode_i),
  .pwm_i  (pwm_i),
  .sync_i (sync_i),
  .out_a  (out_a),
  .out_b  (out_b),
  .out_c  (out_c),
  .out_d  (out_d)
);

// File: tb/hbridge_reverse_dt_test.sv
`timescale 1ns/1ps
module hbridge_reverse_dt_test;

  localparam logic [2:0] FWD = 3'b101;
  localparam logic [2:0] REV = 3'b100;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] mode_i;
  logic [5:0] dead_i;
  logic       pwm_i;
  logic       sync_i;
  logic       out_a, out_b, out_c, out_d;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  hbridge_reverse_dt uut (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .dead_i (dead_i),
    .pwm_i  (pwm_i),
    .sync_i (sync_i),
    .out_a  (out_a),
    .out_b  (out_b),
    .out_c  (out_c),
    .out_d  (out_d)
  );

  // Reference model state, derived from the requirements
  logic       m_dir, m_req, m_wv;
  logic [5:0] m_hold, m_cnt;

  function automatic logic is_brush(input logic [2:0] m);
    return (m == FWD) || (m == REV);
  endfunction

  function automatic logic m_switch(input logic [2:0] m, input logic s);
    return is_brush(m) && m_wv && ((m == FWD) != m_dir) && s;
  endfunction

  function automatic logic [5:0] m_eff(input logic [2:0] m, input logic [5:0] dt);
    if (is_brush(m) && m_wv && ((m == FWD) != m_req)) return dt;
    return m_hold;
  endfunction

  // Expected {a,b,c,d}
  function automatic logic [3:0] m_out(input logic [2:0] m, input logic [5:0] dt,
                                       input logic p, input logic s);
    logic sw, blank, fwd;
    if (!is_brush(m)) return 4'b0000;
    sw    = m_switch(m, s);
    blank = sw ? (m_eff(m, dt) != 0) : (m_cnt != 0);
    fwd   = (!m_wv || sw) ? (m == FWD) : m_dir;
    if (blank) return 4'b0000;
    return fwd ? {p, 1'b0, 1'b0, 1'b1} : {1'b0, 1'b1, p, 1'b0};
  endfunction

  task automatic m_update(input logic [2:0] m, input logic [5:0] dt, input logic s);
    logic sw, tog, fwd;
    logic [5:0] eff;
    fwd = (m == FWD);
    if (!is_brush(m)) begin
      m_dir = fwd; m_req = fwd; m_wv = 1'b0; m_cnt = 0;
    end else begin
      sw  = m_switch(m, s);
      eff = m_eff(m, dt);
      tog = m_wv && (fwd != m_req);
      if (!m_wv || sw) m_dir = fwd;
      if (sw) m_cnt = (eff == 0) ? 6'd0 : eff - 6'd1;
      else if (m_cnt != 0) m_cnt = m_cnt - 6'd1;
      if (tog) m_hold = dt;
      m_req = fwd;
      m_wv  = 1'b1;
    end
  endtask

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: abcd actual=%b expected=%b at %0t", tag, got, exp, $time);
    end
  endtask

  // Drive one cycle (called at a falling edge), compare, then advance.
  task automatic step(input logic [2:0] m, input logic [5:0] dt, input logic p,
                      input logic s, input string tag);
    mode_i = m; dead_i = dt; pwm_i = p; sync_i = s;
    #2;
    check(tag, {out_a, out_b, out_c, out_d}, m_out(m, dt, p, s));
    @(posedge clk);
    m_update(m, dt, s);
    @(negedge clk);
  endtask

  // Drive one cycle and compare to an explicit literal as well.
  task automatic step_lit(input logic [2:0] m, input logic [5:0] dt, input logic p,
                          input logic s, input logic [3:0] lit, input string tag);
    mode_i = m; dead_i = dt; pwm_i = p; sync_i = s;
    #2;
    check(tag, {out_a, out_b, out_c, out_d}, lit);
    check(tag, {out_a, out_b, out_c, out_d}, m_out(m, dt, p, s));
    @(posedge clk);
    m_update(m, dt, s);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [2:0] cur;
    logic [5:0] dt;
    void'($urandom(32'd4242));
    m_dir = 0; m_req = 0; m_wv = 0; m_hold = 0; m_cnt = 0;
    rst_n = 1'b0; mode_i = FWD; dead_i = 6'd3; pwm_i = 1'b1; sync_i = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset quiet", {out_a, out_b, out_c, out_d}, 4'b0000);
    mode_i = 3'b000;
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R2: first brush cycle drives forward at once
    step_lit(FWD, 6'd0, 1'b1, 1'b0, 4'b1001, "R1 immediate fwd");
    step_lit(FWD, 6'd0, 1'b0, 1'b0, 4'b0001, "R2 fwd pwm low");
    step_lit(FWD, 6'd0, 1'b1, 1'b0, 4'b1001, "R2 fwd pwm high");

    // R5/R6: toggle with zero dead time, wait for sync
    step_lit(REV, 6'd0, 1'b1, 1'b0, 4'b1001, "R5 wait for sync");
    step_lit(REV, 6'd0, 1'b1, 1'b0, 4'b1001, "R5 wait for sync");
    step_lit(REV, 6'd0, 1'b1, 1'b1, 4'b0110, "R6 swap in sync cycle");
    step_lit(REV, 6'd0, 1'b0, 1'b0, 4'b0100, "R3 rev pwm low");

    // R7: dead time of 3
    step_lit(FWD, 6'd3, 1'b1, 1'b0, 4'b0110, "R5 pending");
    step_lit(FWD, 6'd3, 1'b1, 1'b1, 4'b0000, "R7 blank sync cycle");
    step_lit(FWD, 6'd3, 1'b1, 1'b0, 4'b0000, "R7 blank 2");
    step_lit(FWD, 6'd3, 1'b1, 1'b0, 4'b0000, "R7 blank 3");
    step_lit(FWD, 6'd3, 1'b1, 1'b0, 4'b1001, "R7 new pair");

    // R8: dead time captured at toggle (2), later change ignored
    step_lit(REV, 6'd2, 1'b1, 1'b0, 4'b1001, "R8 toggle capture");
    step_lit(REV, 6'd7, 1'b1, 1'b0, 4'b1001, "R8 pending");
    step_lit(REV, 6'd7, 1'b1, 1'b1, 4'b0000, "R8 blank 1");
    step_lit(REV, 6'd7, 1'b1, 1'b0, 4'b0000, "R8 blank 2");
    step_lit(REV, 6'd7, 1'b1, 1'b0, 4'b0110, "R8 new pair after 2");

    // R9: toggle then back before sync
    step_lit(FWD, 6'd4, 1'b1, 1'b0, 4'b0110, "R9 toggle");
    step_lit(REV, 6'd4, 1'b1, 1'b0, 4'b0110, "R9 toggle back");
    step_lit(REV, 6'd4, 1'b1, 1'b1, 4'b0110, "R9 no blank at sync");
    step_lit(REV, 6'd4, 1'b0, 1'b0, 4'b0100, "R9 no blank after sync");

    // R10: sync without pending change
    step_lit(REV, 6'd5, 1'b1, 1'b1, 4'b0110, "R10 idle sync");
    step_lit(REV, 6'd5, 1'b1, 1'b0, 4'b0110, "R10 after idle sync");

    // R4: other modes quiet, pending dropped, return drives at once
    step_lit(FWD, 6'd5, 1'b1, 1'b0, 4'b0110, "R4 pending before idle");
    step_lit(3'b111, 6'd5, 1'b1, 1'b1, 4'b0000, "R4 mode 111");
    step_lit(3'b000, 6'd5, 1'b1, 1'b0, 4'b0000, "R4 mode 000");
    step_lit(3'b110, 6'd5, 1'b1, 1'b0, 4'b0000, "R4 mode 110");
    step_lit(FWD, 6'd5, 1'b1, 1'b0, 4'b1001, "R4 return fwd at once");

    // Toggle and sync in the same cycle, dead time 1 (R7)
    step_lit(REV, 6'd1, 1'b1, 1'b1, 4'b0000, "R7 same-cycle blank");
    step_lit(REV, 6'd1, 1'b1, 1'b0, 4'b0110, "R7 same-cycle new pair");

    // Constrained random against the model (R2 R3 R5 R7 R11)
    cur = REV; dt = 6'd2;
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom % 100;
      if (r < 6) begin
        if (is_brush(cur)) cur[0] = ~cur[0];
        else cur = FWD;
      end else if (r < 8) begin
        cur = 3'($urandom % 8);
      end
      if (($urandom % 10) == 0) dt = 6'($urandom % 6);
      step(cur, dt, 1'($urandom % 2), (($urandom % 12) == 0), "R2/R3/R5/R7 random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule